// File: doc/BRIEF.md
# Shared-Select Register File

This block holds four 3-bit words and exposes one write port and one read port. A single 2-bit select bus steers both ports, so the word being written is always the word being shown. The select is read as an unsigned number n, with bit 1 as the most significant bit. A 2-to-4 decoder turns a qualified write strobe into one load line per word. Only line n can go high, and only while the write is being accepted. The read side has one 4-to-1 multiplexer for each data bit, driven by the same select.

Writes are edge triggered on the write-enable input, not level triggered. The whole block runs on a free-running system clock. A two-state qualifier keeps a record of the previous write-enable sample. It accepts a write only on the first clock where write-enable is seen high after being seen low. Holding write-enable high therefore writes once. The qualifier has two states. `ST_ARMED` means write-enable was last seen low. `ST_HELD` means it was last seen high, or reset has just ended. There are two transitions. `ARMED->HELD` fires on write-enable high and produces the load strobe. `HELD->ARMED` fires on write-enable low. A synchronous active-high reset clears every word and enters `ST_HELD`.

Top module: `shared_sel_regfile`

## Requirements
- R1: While reset is high at a clock edge, all four words become 0, so after reset `rd_data` reads 0 for every select value.
- R2: The select is the binary number n = {sel[1], sel[0]}, and reads and writes both address word n.
- R3: A write changes only the word addressed by the select at that edge; the other three words keep their values.
- R4: A write is accepted at the first clock edge where `wr_en` is sampled high after it was sampled low; while `wr_en` stays high, no further write occurs, whatever `wr_data` and `sel` do.
- R5: After `wr_en` is sampled low for at least one edge, the next edge with `wr_en` high performs a new write.
- R6: If `wr_en` is already high when reset ends, no write occurs until `wr_en` has been sampled low and then high.
- R7: The read path is combinational, so a change of `sel` changes `rd_data` within the same cycle, with no clock edge in between.
- R8: After a write edge, `rd_data` shows the written value for that word from the next cycle onward.
- R9: While `wr_en` is low, no decoder line is high and no word changes.
- R10: Bit b of `rd_data` is bit b of word n, for each of the three data bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sel | input | 2 | Shared word select for read and write (bit 1 is the MSB) |
| wr_en | input | 1 | Write enable; a write happens on its sampled 0-to-1 transition |
| wr_data | input | 3 | Data loaded into the selected word |
| rd_data | output | 3 | Contents of the word chosen by `sel` |

## Verification
The assertions check these rules on every cycle: at most one decoder line is high, the high line matches the select, no line is high while `wr_en` is low, a load strobe never lasts two cycles, unaddressed storage stays stable, the read port follows the stored word, and the block stays quiet in the cycle after reset. Some behaviours need a history of stimulus, and only the bench scenarios can show them. Examples are a write-enable that is already high as reset ends, a re-arm through a low cycle followed by a second write, and a long held-high window in which the data changes. The bench also runs long random runs that mix select changes with writes, and compares the output against a reference model on every clock.

// File: rtl/regfile_pkg.sv
package regfile_pkg;

    // Default geometry of the register file
    localparam int unsigned DEF_NUM_REGS = 4;
    localparam int unsigned DEF_DATA_W   = 3;

    // Write-enable qualifier states
    typedef enum logic [0:0] {
        ST_ARMED = 1'b0,  // write-enable last sampled low: next high is a write
        ST_HELD  = 1'b1   // write-enable last sampled high, or reset just ended
    } we_state_t;

endpackage

// File: rtl/regfile_we_fsm.sv
module regfile_we_fsm
    import regfile_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    output logic load_strobe
);

    we_state_t state_q;
    we_state_t state_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HELD;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMED: if (wr_en)  state_d = ST_HELD;   // ARMED->HELD, write fires
            ST_HELD:  if (!wr_en) state_d = ST_ARMED;  // HELD->ARMED, re-arm
            default:  state_d = ST_HELD;
        endcase
    end

    // Output logic
    always_comb begin
        load_strobe = 1'b0;
        unique case (state_q)
            ST_ARMED: load_strobe = wr_en;
            ST_HELD:  load_strobe = 1'b0;
            default:  load_strobe = 1'b0;
        endcase
    end

endmodule

// File: rtl/regfile_decoder.sv
module regfile_decoder #(
    parameter int unsigned NUM_OUT = regfile_pkg::DEF_NUM_REGS,
    localparam int unsigned SEL_W  = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1
) (
    input  logic               enable,
    input  logic [SEL_W-1:0]   sel,
    output logic [NUM_OUT-1:0] lines
);

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_line
        assign lines[i] = enable && (sel == SEL_W'(i));
    end

endmodule

// File: rtl/regfile_storage.sv
module regfile_storage #(
    parameter int unsigned NUM_REGS = regfile_pkg::DEF_NUM_REGS,
    parameter int unsigned DATA_W   = regfile_pkg::DEF_DATA_W
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [NUM_REGS-1:0]              word_en,
    input  logic [DATA_W-1:0]                wr_data,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  words
);

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                words[r] <= '0;
            end else if (word_en[r]) begin
                words[r] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/regfile_bit_mux.sv
module regfile_bit_mux #(
    parameter int unsigned NUM_IN = regfile_pkg::DEF_NUM_REGS,
    localparam int unsigned SEL_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
    input  logic [NUM_IN-1:0] column,
    input  logic [SEL_W-1:0]  sel,
    output logic              bit_out
);

    always_comb begin
        bit_out = 1'b0;
        for (int i = 0; i < NUM_IN; i++) begin
            if (sel == SEL_W'(i)) bit_out = column[i];
        end
    end

endmodule

// File: rtl/shared_sel_regfile.sv
module shared_sel_regfile #(
    parameter int unsigned NUM_REGS = regfile_pkg::DEF_NUM_REGS,
    parameter int unsigned DATA_W   = regfile_pkg::DEF_DATA_W,
    localparam int unsigned SEL_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SEL_W-1:0]  sel,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);

    logic                            load_strobe;
    logic [NUM_REGS-1:0]             word_en;
    logic [NUM_REGS-1:0][DATA_W-1:0] regs;

    // Edge qualifier on write-enable
    regfile_we_fsm u_we_fsm (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .load_strobe (load_strobe)
    );

    // One load line per word
    regfile_decoder #(.NUM_OUT(NUM_REGS)) u_dec (
        .enable (load_strobe),
        .sel    (sel),
        .lines  (word_en)
    );

    regfile_storage #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .word_en (word_en),
        .wr_data (wr_data),
        .words   (regs)
    );

    // One multiplexer per data bit, all sharing the select
    for (genvar b = 0; b < DATA_W; b++) begin : g_rbit
        logic [NUM_REGS-1:0] column;
        for (genvar r = 0; r < NUM_REGS; r++) begin : g_col
            assign column[r] = regs[r][b];
        end
        regfile_bit_mux #(.NUM_IN(NUM_REGS)) u_mux (
            .column  (column),
            .sel     (sel),
            .bit_out (rd_data[b])
        );
    end

endmodule

// File: rtl/regfile_checker.sv
module regfile_checker #(
    parameter int unsigned NUM_REGS = regfile_pkg::DEF_NUM_REGS,
    parameter int unsigned DATA_W   = regfile_pkg::DEF_DATA_W,
    localparam int unsigned SEL_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input logic                            clk,
    input logic                            rst,
    input logic [SEL_W-1:0]                sel,
    input logic                            wr_en,
    input logic [DATA_W-1:0]               wr_data,
    input logic [DATA_W-1:0]               rd_data,
    input logic                            load_strobe,
    input logic [NUM_REGS-1:0]             word_en,
    input logic [NUM_REGS-1:0][DATA_W-1:0] regs
);

    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    // R1 / R6: the cycle after a reset edge holds cleared words and no load
    always_ff @(posedge clk) begin
        if (rst_q === 1'b1) begin
            assert_reset_clears_R1: assert (regs == '0);
            if (!rst) begin
                assert_no_load_after_reset_R6: assert (!load_strobe);
            end
        end
    end

    assert_one_line_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(word_en));

    assert_line_matches_sel_R2: assert property (@(posedge clk) disable iff (rst)
        (word_en != '0) |-> word_en[sel]);

    assert_quiet_when_low_R9: assert property (@(posedge clk) disable iff (rst)
        !wr_en |-> (word_en == '0));

    assert_single_write_R4: assert property (@(posedge clk) disable iff (rst)
        load_strobe |=> !load_strobe);

    assert_hold_without_load_R3: assert property (@(posedge clk) disable iff (rst)
        (word_en == '0) |=> $stable(regs));

    assert_visible_next_R8: assert property (@(posedge clk) disable iff (rst)
        load_strobe |=> (!$stable(sel) || rd_data == $past(wr_data)));

    assert_read_follows_R10: assert property (@(posedge clk) disable iff (rst)
        rd_data == regs[sel]);

endmodule

bind shared_sel_regfile regfile_checker #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .sel         (sel),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .rd_data     (rd_data),
    .load_strobe (load_strobe),
    .word_en     (word_en),
    .regs        (regs)
);

// File: tb/shared_sel_regfile_tb.sv
`timescale 1ns/1ps
module shared_sel_regfile_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] sel = 2'd0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_data = 3'd0;
    logic [2:0] rd_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference model
    logic [2:0] ref_mem [4] = '{3'd0, 3'd0, 3'd0, 3'd0};
    bit         armed = 1'b0;

    always #2.5 clk = ~clk;

    shared_sel_regfile u_dut (
        .clk     (clk),
        .rst     (rst),
        .sel     (sel),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data)
    );

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 4; i++) ref_mem[i] = 3'd0;
            armed = 1'b0;
        end else begin
            if (armed && wr_en) ref_mem[sel] = wr_data;
            armed = !wr_en;
        end
    end

    task automatic chk(input string tag);
        checks++;
        if (rd_data !== ref_mem[sel]) begin
            fails++;
            $display("FAIL %s: sel=%0d rd_data=%0d expected %0d",
                     tag, sel, rd_data, ref_mem[sel]);
        end
    endtask

    task automatic step(input logic r, input logic [1:0] s, input logic we,
                        input logic [2:0] d, input string tag);
        @(negedge clk);
        rst = r; sel = s; wr_en = we; wr_data = d;
        #1 chk(tag);
    endtask

    // Check a fixed value without advancing the clock
    task automatic expect_sel(input logic [1:0] s, input logic [2:0] exp_v,
                              input string tag);
        sel = s;
        #0.5;
        checks++;
        if (rd_data !== exp_v || rd_data !== ref_mem[s]) begin
            fails++;
            $display("FAIL %s: sel=%0d rd_data=%0d expected %0d", tag, s, rd_data, exp_v);
        end
    endtask

    initial begin
        // R1: reset, with write-enable already high for R6
        step(1, 2'd0, 1'b0, 3'd7, "R1");
        step(1, 2'd1, 1'b1, 3'd5, "R1");
        step(0, 2'd1, 1'b1, 3'd5, "R6");
        step(0, 2'd1, 1'b1, 3'd6, "R6");
        @(negedge clk);
        for (int s = 0; s < 4; s++) expect_sel(2'(s), 3'd0, "R1");
        // R4: low then high writes word 1
        step(0, 2'd1, 1'b0, 3'd6, "R9");
        step(0, 2'd1, 1'b1, 3'd6, "R4");
        step(0, 2'd1, 1'b1, 3'd2, "R8");
        step(0, 2'd2, 1'b1, 3'd3, "R4");
        @(negedge clk);
        expect_sel(2'd1, 3'd6, "R8");
        expect_sel(2'd2, 3'd0, "R4");
        // R5: re-arm and write word 2
        step(0, 2'd2, 1'b0, 3'd3, "R5");
        step(0, 2'd2, 1'b1, 3'd3, "R5");
        step(0, 2'd2, 1'b0, 3'd0, "R5");
        @(negedge clk);
        expect_sel(2'd2, 3'd3, "R5");
        // R2 / R10: word 3 holds a pattern with distinct bits, word 0 another
        step(0, 2'd3, 1'b1, 3'd4, "R2");
        step(0, 2'd0, 1'b0, 3'd1, "R9");
        step(0, 2'd0, 1'b1, 3'd1, "R10");
        step(0, 2'd0, 1'b0, 3'd7, "R9");
        // R9: many cycles low with changing data and select
        for (int i = 0; i < 8; i++) step(0, 2'(i), 1'b0, 3'(7 - i), "R9");
        @(negedge clk);
        // R3 / R7: sweep reads within one cycle
        expect_sel(2'd0, 3'd1, "R7");
        expect_sel(2'd1, 3'd6, "R3");
        expect_sel(2'd2, 3'd3, "R3");
        expect_sel(2'd3, 3'd4, "R10");
        // Random mix against the reference model
        for (int i = 0; i < 2000; i++) begin
            step(0, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                 3'($urandom_range(0, 7)), "R8");
        end
        // R1 again: reset mid-run clears everything
        step(1, 2'd3, 1'b0, 3'd0, "R1");
        step(0, 2'd3, 1'b0, 3'd0, "R1");
        @(negedge clk);
        for (int s = 0; s < 4; s++) expect_sel(2'(s), 3'd0, "R1");
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                fails++;
                $display("FAIL watchdog: run did not complete, actual hung expected done");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule